// File: doc/BRIEF.md
# Time-Triggered Basic Cycle Counter

This block keeps the index of the basic cycle that a time-triggered CAN node is currently in, inside the repeating matrix cycle. The index is a 6-bit counter. A node that may act as time master advances the counter on its own whenever the running cycle time reaches the transmit-trigger time of the reference-message slot. Every node, master-capable or slave, overwrites the counter with the cycle number carried in a valid received reference message. A 3-bit configuration code selects how many basic cycles make up a matrix cycle. One code of that field holds the counter at zero.

A small register port lets software read and write the counter. The same port gives access to a sticky status flag, which records that the 16-bit free-running timer wrapped while the node ran event-triggered. The bit engine, the mailboxes and the acceptance logic stay outside this block. They reach it only as strobes and data buses.

Top module: `ttcc_top`

## Requirements
- R1: Register address 0 returns the counter in bits [5:0], and bits [15:6] always read 0; written upper bits are discarded. Address 1 returns the overrun flag in bit 0, and its other bits read 0. `cpu_rdata` is registered: it shows the state of the register addressed at a clock edge after that edge.
- R2: With `is_master`=1, the counter steps up by one on the clock edge at which `cycle_time` first equals `trig_time`.
- R3: In either mode, a `ref_valid` strobe loads `ref_cycle` (bits [5:0] of the reference message's first data byte) into the counter at the next edge.
- R4: With `is_master`=0, a match between `cycle_time` and `trig_time` leaves the counter unchanged. Only reference loads and register writes change it.
- R5: While `cyc_cfg`=3'b111, the counter is 0 from the next edge on. Reference loads, register writes and trigger matches are ignored, and address 0 reads 0.
- R6: The overrun flag (address 1, bit 0) is set when `ev_mode`=1 and `timer_value` goes from 16'hFFFF in one cycle to 16'h0000 in the next. No other sequence sets it, and a wrap with `ev_mode`=0 does not set it. Writing 1 to address 1, bit 0 clears the flag; writing 0 leaves it set.
- R7: For `cyc_cfg`=N with N from 0 to 6, a master step from any value at or above 2^N−1 gives 0, so a matrix cycle holds 2^N basic cycles.
- R8: A reference load and a trigger-match step in the same cycle give the loaded value.
- R9: A write to address 0 takes effect at the next edge. A reference load in the same cycle overrides it, and it overrides a trigger-match step in the same cycle.
- R10: If a wrap event and a write-1 clear reach the flag in the same cycle, the flag ends up set.
- R11: A match that stays true for several clocks produces one step. Another step needs the match to go false and then true again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = potential time master, 0 = time slave |
| ev_mode | input | 1 | 1 = event-triggered operation (enables overrun detection) |
| cyc_cfg | input | 3 | Matrix length code: 2^N basic cycles, 3'b111 pins counter to 0 |
| cycle_time | input | 16 | Running cycle time |
| trig_time | input | 16 | Transmit-trigger time of the reference-message slot |
| ref_valid | input | 1 | One-cycle strobe: valid reference message received |
| ref_cycle | input | 6 | Bits [5:0] of the reference message's first data byte |
| timer_value | input | 16 | Free-running 16-bit timer |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register address: 0 counter, 1 status |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Registered read data |
| cycle_count | output | 6 | Current basic cycle index |
| overrun_flag | output | 1 | Timer overrun flag |

## Verification
The hardest situations to reach are collisions: a reference load, a register write and a match edge on the same clock, and a wrap event that coincides with a write-1 clear. Only ordinary ports are available to produce them. The bench drives all colliding inputs at one falling edge, so they are seen at the same rising edge, and it checks the winner half a clock later. For the matrix length, the bench sweeps every code from 0 to 6 in master mode, driving 2^N+3 match episodes per code so that each wrap is crossed. It also loads values above the limit to check the clamp-to-zero path.

// File: rtl/ttcc_pkg.sv
package ttcc_pkg;

  // register addresses seen at the CPU port
  localparam int unsigned ADDR_CNT  = 0;
  localparam int unsigned ADDR_STAT = 1;

  // update source chosen for the cycle counter in a given clock
  typedef enum logic [2:0] {
    UPD_HOLD = 3'd0,
    UPD_ZERO = 3'd1,
    UPD_REF  = 3'd2,
    UPD_CPU  = 3'd3,
    UPD_STEP = 3'd4
  } upd_sel_e;

endpackage

// File: rtl/ttcc_match_edge.sv
module ttcc_match_edge #(
  parameter int unsigned CT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CT_W-1:0] cur_time,
  input  logic [CT_W-1:0] hit_time,
  output logic            hit_pulse
);

  logic hit_now;
  logic hit_seen;

  assign hit_now = (cur_time == hit_time);

  always_ff @(posedge clk) begin
    if (rst) hit_seen <= 1'b0;
    else     hit_seen <= hit_now;
  end

  // only the first clock of an equality episode counts
  assign hit_pulse = hit_now & ~hit_seen;

endmodule

// File: rtl/ttcc_cycle_ctr.sv
module ttcc_cycle_ctr
  import ttcc_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic [CFG_W-1:0] cfg,
  input  logic             step,
  input  logic             ref_ld,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             cpu_ld,
  input  logic [CNT_W-1:0] cpu_val,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CFG_W-1:0] CFG_PIN = '1;

  upd_sel_e         sel;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] stepped;

  // last index of the matrix cycle for the configured length
  always_comb begin
    if (int'(cfg) >= int'(CNT_W)) lim = '1;
    else                          lim = CNT_W'((1 << cfg) - 1);
  end

  assign stepped = (cnt >= lim) ? '0 : cnt + 1'b1;

  // pin code > reference load > register write > master step
  always_comb begin
    if (cfg == CFG_PIN)     sel = UPD_ZERO;
    else if (ref_ld)        sel = UPD_REF;
    else if (cpu_ld)        sel = UPD_CPU;
    else if (master & step) sel = UPD_STEP;
    else                    sel = UPD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case (sel)
        UPD_ZERO: cnt <= '0;
        UPD_REF:  cnt <= ref_val;
        UPD_CPU:  cnt <= cpu_val;
        UPD_STEP: cnt <= stepped;
        default:  cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/ttcc_ovf_flag.sv
module ttcc_ovf_flag #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_mode,
  input  logic [TMR_W-1:0] tmr,
  input  logic             clr,
  output logic             flag
);

  logic [TMR_W-1:0] tmr_prev;
  logic             wrap;

  always_ff @(posedge clk) begin
    tmr_prev <= tmr;
  end

  assign wrap = ev_mode & (&tmr_prev) & ~(|tmr);

  // a wrap in the same clock as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (wrap) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

endmodule

// File: rtl/ttcc_regif.sv
module ttcc_regif
  import ttcc_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  input  logic              pinned,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              flag_clr,
  output logic [REG_W-1:0]  rdata
);

  logic hit_cnt;
  logic hit_stat;
  logic unused_wdata_hi;

  assign hit_cnt  = (addr == ADDR_W'(ADDR_CNT));
  assign hit_stat = (addr == ADDR_W'(ADDR_STAT));

  assign cnt_ld   = wr & hit_cnt;
  assign cnt_val  = wdata[CNT_W-1:0];
  assign flag_clr = wr & hit_stat & wdata[0];

  assign unused_wdata_hi = ^wdata[REG_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (hit_cnt) begin
      rdata <= pinned ? '0 : REG_W'(cnt);
    end else if (hit_stat) begin
      rdata <= REG_W'(flag);
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/ttcc_top.sv
module ttcc_top #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned CFG_W  = 3,
  parameter int unsigned CT_W   = 16,
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              ev_mode,
  input  logic [CFG_W-1:0]  cyc_cfg,
  input  logic [CT_W-1:0]   cycle_time,
  input  logic [CT_W-1:0]   trig_time,
  input  logic              ref_valid,
  input  logic [CNT_W-1:0]  ref_cycle,
  input  logic [TMR_W-1:0]  timer_value,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic [CNT_W-1:0]  cycle_count,
  output logic              overrun_flag
);

  localparam logic [CFG_W-1:0] CFG_PIN = '1;

  logic             step_pulse;
  logic             wr_cnt;
  logic [CNT_W-1:0] wr_val;
  logic             wr_clr;
  logic             pinned;

  assign pinned = (cyc_cfg == CFG_PIN);

  ttcc_match_edge #(.CT_W(CT_W)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .cur_time  (cycle_time),
    .hit_time  (trig_time),
    .hit_pulse (step_pulse)
  );

  ttcc_regif #(.REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .wr       (cpu_wr),
    .addr     (cpu_addr),
    .wdata    (cpu_wdata),
    .cnt      (cycle_count),
    .flag     (overrun_flag),
    .pinned   (pinned),
    .cnt_ld   (wr_cnt),
    .cnt_val  (wr_val),
    .flag_clr (wr_clr),
    .rdata    (cpu_rdata)
  );

  ttcc_cycle_ctr #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .master  (is_master),
    .cfg     (cyc_cfg),
    .step    (step_pulse),
    .ref_ld  (ref_valid),
    .ref_val (ref_cycle),
    .cpu_ld  (wr_cnt),
    .cpu_val (wr_val),
    .cnt     (cycle_count)
  );

  ttcc_ovf_flag #(.TMR_W(TMR_W)) u_ovf (
    .clk     (clk),
    .rst     (rst),
    .ev_mode (ev_mode),
    .tmr     (timer_value),
    .clr     (wr_clr),
    .flag    (overrun_flag)
  );

endmodule

// File: rtl/ttcc_checker.sv
module ttcc_checker #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned CFG_W  = 3,
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              is_master,
  input logic              ev_mode,
  input logic [CFG_W-1:0]  cyc_cfg,
  input logic              ref_valid,
  input logic [CNT_W-1:0]  ref_cycle,
  input logic [TMR_W-1:0]  timer_value,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [REG_W-1:0]  cpu_rdata,
  input logic [CNT_W-1:0]  cycle_count,
  input logic              overrun_flag
);

  localparam logic [CFG_W-1:0] CFG_PIN = '1;

  logic wr_cnt;
  logic wr_clr_any;
  assign wr_cnt     = cpu_wr && (cpu_addr == ADDR_W'(0));
  assign wr_clr_any = cpu_wr && (cpu_addr == ADDR_W'(1));

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    cpu_rdata[REG_W-1:CNT_W] == '0); // R1

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cyc_cfg != CFG_PIN && !ref_valid && !wr_cnt) |=>
      (cycle_count == $past(cycle_count)) ||
      (cycle_count == $past(cycle_count) + CNT_W'(1)) ||
      (cycle_count == '0)); // R2

  AST_REF_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && cyc_cfg != CFG_PIN) |=> cycle_count == $past(ref_cycle)); // R3

  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!is_master && !ref_valid && !wr_cnt && cyc_cfg != CFG_PIN) |=> $stable(cycle_count)); // R4

  AST_PINNED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cyc_cfg == CFG_PIN) |=> cycle_count == '0); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun_flag && !wr_clr_any) |=> overrun_flag); // R6

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst)
    (ev_mode && timer_value == '0 && $past(timer_value) == '1) |=> overrun_flag); // R10

endmodule

bind ttcc_top ttcc_checker #(
  .CNT_W(CNT_W), .CFG_W(CFG_W), .TMR_W(TMR_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .is_master    (is_master),
  .ev_mode      (ev_mode),
  .cyc_cfg      (cyc_cfg),
  .ref_valid    (ref_valid),
  .ref_cycle    (ref_cycle),
  .timer_value  (timer_value),
  .cpu_wr       (cpu_wr),
  .cpu_addr     (cpu_addr),
  .cpu_rdata    (cpu_rdata),
  .cycle_count  (cycle_count),
  .overrun_flag (overrun_flag)
);

// File: tb/sim_ttcc_top.sv
`timescale 1ns/1ps
module sim_ttcc_top;

  localparam logic [15:0] TRIG = 16'h1234;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        is_master = 1'b0;
  logic        ev_mode = 1'b0;
  logic [2:0]  cyc_cfg = 3'd6;
  logic [15:0] cycle_time = 16'h0000;
  logic [15:0] trig_time = TRIG;
  logic        ref_valid = 1'b0;
  logic [5:0]  ref_cycle = 6'd0;
  logic [15:0] timer_value = 16'h0100;
  logic        cpu_wr = 1'b0;
  logic [0:0]  cpu_addr = 1'b0;
  logic [15:0] cpu_wdata = 16'h0000;
  logic [15:0] cpu_rdata;
  logic [5:0]  cycle_count;
  logic        overrun_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ttcc_top u0 (
    .clk(clk), .rst(rst), .is_master(is_master), .ev_mode(ev_mode),
    .cyc_cfg(cyc_cfg), .cycle_time(cycle_time), .trig_time(trig_time),
    .ref_valid(ref_valid), .ref_cycle(ref_cycle), .timer_value(timer_value),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cycle_count(cycle_count), .overrun_flag(overrun_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic a, input logic [15:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = 16'h0000;
  endtask

  task automatic cpu_read(input logic a, output int v);
    cpu_addr = a;
    @(negedge clk);
    v = int'(cpu_rdata);
  endtask

  // one match episode: equal for three clocks, then unequal for one
  task automatic match_episode(input string req, input int exp_after);
    cycle_time = TRIG;
    @(negedge clk);
    chk(req, int'(cycle_count), exp_after);
    @(negedge clk);
    @(negedge clk);
    chk("R11", int'(cycle_count), exp_after);
    cycle_time = 16'h0000;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    int exp;
    int lim;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R1", int'(cycle_count), 0);
    chk("R6", int'(overrun_flag), 0);
    cpu_read(1'b0, v); chk("R1", v, 0);

    // R1/R9: register write and read back with junk in the upper bits
    for (int k = 0; k < 64; k++) begin
      cpu_write(1'b0, 16'hFFC0 | 16'(k));
      chk("R9", int'(cycle_count), k);
      cpu_read(1'b0, v); chk("R1", v, k);
    end

    // R2/R7: master stepping for every matrix length
    is_master = 1'b1;
    for (int n = 0; n <= 6; n++) begin
      cyc_cfg = 3'(n);
      cpu_write(1'b0, 16'h0000);
      exp = 0;
      lim = (1 << n) - 1;
      for (int e = 0; e < (1 << n) + 3; e++) begin
        exp = (exp >= lim) ? 0 : exp + 1;
        match_episode("R2/R7", exp);
      end
    end

    // R7: a loaded value above the limit steps to zero
    cyc_cfg = 3'd2;
    ref_valid = 1'b1; ref_cycle = 6'd50;
    @(negedge clk);
    ref_valid = 1'b0;
    chk("R3", int'(cycle_count), 50);
    match_episode("R7", 0);

    // R3: reference load sweep, both modes
    cyc_cfg = 3'd6;
    for (int m = 0; m < 2; m++) begin
      is_master = m[0];
      for (int k = 0; k < 64; k++) begin
        ref_valid = 1'b1; ref_cycle = 6'(63 - k);
        @(negedge clk);
        ref_valid = 1'b0;
        chk("R3", int'(cycle_count), 63 - k);
      end
    end

    // R4: slave ignores matches
    is_master = 1'b0;
    cpu_write(1'b0, 16'd7);
    for (int e = 0; e < 5; e++) match_episode("R4", 7);

    // R8: reference beats match step
    is_master = 1'b1;
    cpu_write(1'b0, 16'd10);
    cycle_time = TRIG; ref_valid = 1'b1; ref_cycle = 6'd40;
    @(negedge clk);
    ref_valid = 1'b0;
    chk("R8", int'(cycle_count), 40);
    cycle_time = 16'h0000;
    @(negedge clk);

    // R9: reference beats register write
    ref_valid = 1'b1; ref_cycle = 6'd33;
    cpu_write(1'b0, 16'd5);
    ref_valid = 1'b0;
    chk("R9", int'(cycle_count), 33);

    // R9: register write beats match step
    cycle_time = TRIG;
    cpu_write(1'b0, 16'd20);
    chk("R9", int'(cycle_count), 20);
    cycle_time = 16'h0000;
    @(negedge clk);

    // R5: pin code holds zero
    cyc_cfg = 3'd7;
    @(negedge clk);
    chk("R5", int'(cycle_count), 0);
    ref_valid = 1'b1; ref_cycle = 6'd17;
    @(negedge clk);
    ref_valid = 1'b0;
    chk("R5", int'(cycle_count), 0);
    cpu_write(1'b0, 16'd9);
    chk("R5", int'(cycle_count), 0);
    match_episode("R5", 0);
    cpu_read(1'b0, v); chk("R5", v, 0);
    cyc_cfg = 3'd6;

    // R6: overrun flag
    ev_mode = 1'b1;
    timer_value = 16'hFFFE; @(negedge clk);
    timer_value = 16'hFFFF; @(negedge clk);
    chk("R6", int'(overrun_flag), 0);
    timer_value = 16'h0000; @(negedge clk);
    chk("R6", int'(overrun_flag), 1);
    cpu_read(1'b1, v); chk("R1", v, 1);
    cpu_write(1'b1, 16'h0000);
    chk("R6", int'(overrun_flag), 1);
    cpu_write(1'b1, 16'h0001);
    chk("R6", int'(overrun_flag), 0);
    timer_value = 16'hFFFF; @(negedge clk);
    timer_value = 16'h0001; @(negedge clk);
    chk("R6", int'(overrun_flag), 0);
    ev_mode = 1'b0;
    timer_value = 16'hFFFF; @(negedge clk);
    timer_value = 16'h0000; @(negedge clk);
    chk("R6", int'(overrun_flag), 0);

    // R10: wrap and clear in the same cycle
    ev_mode = 1'b1;
    timer_value = 16'hFFFF; @(negedge clk);
    timer_value = 16'h0000;
    cpu_write(1'b1, 16'h0001);
    chk("R10", int'(overrun_flag), 1);
    cpu_write(1'b1, 16'h0001);
    chk("R6", int'(overrun_flag), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule